// File: doc/BRIEF.md
# Processor Exception Entry and Return Sequencer

This block owns the program counter, the current status word and the banked stack pointer, link register and saved-status registers of a small 32-bit core. Each cycle it looks at the pending exception requests. It picks the winner by a fixed priority, with IRQ and FIQ gated by their mask bits in the status word. It then performs the whole entry in one clock edge: the old status goes into the saved-status register of the target mode, the mode field and mask bits are rewritten, the target mode's link register receives the return address, and the PC jumps to the exception's vector.

The core signals a return with `ret_i`. In any mode that has a saved-status register, the status word is reloaded from that register and the PC from the link register in the same edge. When no exception or return is in progress, the core updates the PC and the status word through plain load ports. A one-cycle `entry_taken_o` pulse and the taken vector let the surrounding logic or a model follow every entry.

Top module: `exc_ctrl`

## Requirements
- R1: After the asynchronous reset, `pc_o` is 0x00000000, `cpsr_o` is 0x000000D3 (supervisor mode, I=1, F=1) and `entry_taken_o` is 0.
- R2: The status word holds the mode in bits 4:0, F in bit 6 and I in bit 7. An accepted exception sets the PC and mode as follows: reset 0x00 / 10011, undefined 0x04 / 11011, software interrupt 0x08 / 10011, prefetch abort 0x0C / 10111, data abort 0x10 / 10111, IRQ 0x18 / 10010, FIQ 0x1C / 10001. Bits 31:8 and bit 5 are kept.
- R3: On entry, the saved-status register of the entered mode receives the status word that was current before entry. `spsr_o` shows the saved-status register of the current mode, and reads 0 in user (10000) and system (11111) mode.
- R4: On entry, the link register of the entered mode receives the address of the interrupted instruction (`pc_o` before entry) plus 4.
- R5: Every entry sets I to 1. F is set to 1 only for reset and FIQ; every other entry keeps F unchanged.
- R6: When several requests are pending, only one is taken, in the order reset, data abort, FIQ, IRQ, prefetch abort, undefined, software interrupt.
- R7: An IRQ request has no effect while I=1, and an FIQ request has no effect while F=1. Lower-priority requests still compete as if the masked request were absent.
- R8: `ret_i` in a mode with a saved-status register loads the status word from that register and the PC from that mode's link register in the same edge. In user or system mode, `ret_i` changes nothing.
- R9: User and system share one stack pointer, and each exception mode has its own. `sp_we_i` writes the current mode's stack pointer, and `sp_o` reads it.
- R10: `entry_taken_o` is high for exactly the one cycle after the edge that performed the entry, and during that cycle `entry_vector_o` equals the new PC.
- R11: In a single cycle, exception entry overrides `ret_i`, and `ret_i` overrides the `pc_ld_i` and `cpsr_ld_i` loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_rst_i | input | 1 | Soft reset exception request |
| req_und_i | input | 1 | Undefined instruction request |
| req_swi_i | input | 1 | Software interrupt request |
| req_pabt_i | input | 1 | Prefetch abort request |
| req_dabt_i | input | 1 | Data abort request |
| req_irq_i | input | 1 | Normal interrupt request |
| req_fiq_i | input | 1 | Fast interrupt request |
| ret_i | input | 1 | Exception return |
| pc_ld_i | input | 1 | Load PC from pc_val_i |
| pc_val_i | input | 32 | Next PC from the core |
| cpsr_ld_i | input | 1 | Load status word from cpsr_val_i |
| cpsr_val_i | input | 32 | New status word from the core |
| sp_we_i | input | 1 | Write current mode's stack pointer |
| sp_wdata_i | input | 32 | Stack pointer write data |
| pc_o | output | 32 | Program counter |
| cpsr_o | output | 32 | Current status word |
| spsr_o | output | 32 | Saved status of current mode |
| lr_o | output | 32 | Link register of current mode |
| sp_o | output | 32 | Stack pointer of current mode |
| entry_taken_o | output | 1 | One-cycle pulse after an entry |
| entry_vector_o | output | 32 | Vector of the last entry |

## Verification
The assertions assume that the request and return inputs are stable around the rising edge. They also assume the status word only ever holds one of the listed mode encodings, because an unknown mode falls back to the user bank and would weaken the saved-status checks. The bench drives every input one nanosecond after an edge, loads only legal status values through `cpsr_ld_i`, and sets up each scenario with an explicit user-mode load before raising requests.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int XLEN      = 32;
  localparam int NUM_EXC   = 7;
  localparam int NUM_BANKS = 6;
  localparam int BANK_W    = $clog2(NUM_BANKS);
  localparam int I_BIT     = 7;
  localparam int F_BIT     = 6;

  localparam logic [4:0] MODE_USR = 5'b10000;
  localparam logic [4:0] MODE_FIQ = 5'b10001;
  localparam logic [4:0] MODE_IRQ = 5'b10010;
  localparam logic [4:0] MODE_SVC = 5'b10011;
  localparam logic [4:0] MODE_ABT = 5'b10111;
  localparam logic [4:0] MODE_UND = 5'b11011;
  localparam logic [4:0] MODE_SYS = 5'b11111;

  // index order is acceptance priority, 0 highest
  typedef enum logic [2:0] {
    EXC_RST  = 3'd0,
    EXC_DABT = 3'd1,
    EXC_FIQ  = 3'd2,
    EXC_IRQ  = 3'd3,
    EXC_PABT = 3'd4,
    EXC_UND  = 3'd5,
    EXC_SWI  = 3'd6
  } exc_e;

  function automatic logic [XLEN-1:0] exc_vector(exc_e e);
    case (e)
      EXC_RST:  return XLEN'(32'h00);
      EXC_UND:  return XLEN'(32'h04);
      EXC_SWI:  return XLEN'(32'h08);
      EXC_PABT: return XLEN'(32'h0C);
      EXC_DABT: return XLEN'(32'h10);
      EXC_IRQ:  return XLEN'(32'h18);
      default:  return XLEN'(32'h1C);
    endcase
  endfunction

  function automatic logic [4:0] exc_mode(exc_e e);
    case (e)
      EXC_RST, EXC_SWI:   return MODE_SVC;
      EXC_UND:            return MODE_UND;
      EXC_PABT, EXC_DABT: return MODE_ABT;
      EXC_IRQ:            return MODE_IRQ;
      default:            return MODE_FIQ;
    endcase
  endfunction

  function automatic logic exc_sets_f(exc_e e);
    return (e == EXC_RST) || (e == EXC_FIQ);
  endfunction

  // bank 0 is shared by user and system and has no saved status
  function automatic logic [BANK_W-1:0] bank_of(logic [4:0] m);
    case (m)
      MODE_FIQ: return BANK_W'(1);
      MODE_IRQ: return BANK_W'(2);
      MODE_SVC: return BANK_W'(3);
      MODE_ABT: return BANK_W'(4);
      MODE_UND: return BANK_W'(5);
      default:  return BANK_W'(0);
    endcase
  endfunction
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
#(
  parameter int N = NUM_EXC
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic         irq_mask_i,
  input  logic         fiq_mask_i,
  output logic         valid_o,
  output exc_e         sel_o,
  output logic [N-1:0] grant_o
);
  logic [N-1:0] live;

  always_comb begin
    live = req_i;
    live[EXC_IRQ] = req_i[EXC_IRQ] & ~irq_mask_i;
    live[EXC_FIQ] = req_i[EXC_FIQ] & ~fiq_mask_i;
  end

  always_comb begin
    grant_o = '0;
    sel_o   = EXC_RST;
    valid_o = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (live[k] && !valid_o) begin
        valid_o    = 1'b1;
        grant_o[k] = 1'b1;
        sel_o      = exc_e'(k);
      end
    end
  end

  a_r6_single_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o) && (valid_o == (grant_o != '0)));
  a_r7_irq_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_mask_i |-> !grant_o[EXC_IRQ]);
  a_r7_fiq_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fiq_mask_i |-> !grant_o[EXC_FIQ]);
endmodule

// File: rtl/exc_bank.sv
module exc_bank
  import exc_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int NB = NUM_BANKS,
  localparam int IW = $clog2(NB)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [IW-1:0] cur_idx_i,
  input  logic          ent_we_i,
  input  logic [IW-1:0] ent_idx_i,
  input  logic [W-1:0]  ent_lr_i,
  input  logic [W-1:0]  ent_spsr_i,
  input  logic          sp_we_i,
  input  logic [W-1:0]  sp_wdata_i,
  output logic [W-1:0]  lr_o,
  output logic [W-1:0]  sp_o,
  output logic [W-1:0]  spsr_o,
  output logic          has_spsr_o
);
  logic [W-1:0] lr_q   [NB];
  logic [W-1:0] sp_q   [NB];
  logic [W-1:0] spsr_q [NB];

  for (genvar b = 0; b < NB; b++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lr_q[b] <= '0;
        sp_q[b] <= '0;
      end else begin
        if (ent_we_i && ent_idx_i == IW'(b)) lr_q[b] <= ent_lr_i;
        if (sp_we_i && cur_idx_i == IW'(b))  sp_q[b] <= sp_wdata_i;
      end
    end

    if (b == 0) begin : g_nosave
      assign spsr_q[b] = '0;
    end else begin : g_save
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) spsr_q[b] <= '0;
        else if (ent_we_i && ent_idx_i == IW'(b)) spsr_q[b] <= ent_spsr_i;
      end
    end
  end

  assign lr_o       = lr_q[cur_idx_i];
  assign sp_o       = sp_q[cur_idx_i];
  assign spsr_o     = spsr_q[cur_idx_i];
  assign has_spsr_o = (cur_idx_i != '0);

  a_r9_sp_other_banks_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sp_we_i && !(ent_we_i && ent_idx_i == cur_idx_i) |=> $stable(sp_o) || $changed(cur_idx_i));
endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_rst_i,
  input  logic        req_und_i,
  input  logic        req_swi_i,
  input  logic        req_pabt_i,
  input  logic        req_dabt_i,
  input  logic        req_irq_i,
  input  logic        req_fiq_i,
  input  logic        ret_i,
  input  logic        pc_ld_i,
  input  logic [31:0] pc_val_i,
  input  logic        cpsr_ld_i,
  input  logic [31:0] cpsr_val_i,
  input  logic        sp_we_i,
  input  logic [31:0] sp_wdata_i,
  output logic [31:0] pc_o,
  output logic [31:0] cpsr_o,
  output logic [31:0] spsr_o,
  output logic [31:0] lr_o,
  output logic [31:0] sp_o,
  output logic        entry_taken_o,
  output logic [31:0] entry_vector_o
);
  localparam logic [XLEN-1:0] RESET_CPSR = XLEN'({MODE_SVC == 5'b10011 ? 24'h0 : 24'h0, 3'b110, MODE_SVC});

  logic [XLEN-1:0] pc_q, pc_d, cpsr_q, cpsr_d, vec_q, vec_d;
  logic            taken_q;
  logic [NUM_EXC-1:0] reqs, grant;
  logic            ent_valid, ret_take, has_spsr;
  exc_e            ent_sel;
  logic [XLEN-1:0] bank_lr, bank_sp, bank_spsr, ent_cpsr;
  logic [BANK_W-1:0] cur_idx, ent_idx;

  always_comb begin
    reqs = '0;
    reqs[EXC_RST]  = req_rst_i;
    reqs[EXC_DABT] = req_dabt_i;
    reqs[EXC_FIQ]  = req_fiq_i;
    reqs[EXC_IRQ]  = req_irq_i;
    reqs[EXC_PABT] = req_pabt_i;
    reqs[EXC_UND]  = req_und_i;
    reqs[EXC_SWI]  = req_swi_i;
  end

  exc_arbiter #(.N(NUM_EXC)) u_arb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (reqs),
    .irq_mask_i (cpsr_q[I_BIT]),
    .fiq_mask_i (cpsr_q[F_BIT]),
    .valid_o    (ent_valid),
    .sel_o      (ent_sel),
    .grant_o    (grant)
  );

  assign cur_idx = bank_of(cpsr_q[4:0]);
  assign ent_idx = bank_of(exc_mode(ent_sel));

  exc_bank #(.W(XLEN), .NB(NUM_BANKS)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cur_idx_i  (cur_idx),
    .ent_we_i   (ent_valid),
    .ent_idx_i  (ent_idx),
    .ent_lr_i   (pc_q + XLEN'(4)),
    .ent_spsr_i (cpsr_q),
    .sp_we_i    (sp_we_i),
    .sp_wdata_i (sp_wdata_i),
    .lr_o       (bank_lr),
    .sp_o       (bank_sp),
    .spsr_o     (bank_spsr),
    .has_spsr_o (has_spsr)
  );

  // new status word: keep flags and bit 5, rewrite masks and mode
  always_comb begin
    ent_cpsr        = cpsr_q;
    ent_cpsr[4:0]   = exc_mode(ent_sel);
    ent_cpsr[I_BIT] = 1'b1;
    if (exc_sets_f(ent_sel)) ent_cpsr[F_BIT] = 1'b1;
  end

  assign ret_take = ret_i && has_spsr && !ent_valid;

  always_comb begin
    pc_d   = pc_q;
    cpsr_d = cpsr_q;
    vec_d  = vec_q;
    if (ent_valid) begin
      pc_d   = exc_vector(ent_sel);
      cpsr_d = ent_cpsr;
      vec_d  = exc_vector(ent_sel);
    end else if (ret_take) begin
      pc_d   = bank_lr;
      cpsr_d = bank_spsr;
    end else begin
      if (pc_ld_i)   pc_d   = pc_val_i;
      if (cpsr_ld_i) cpsr_d = cpsr_val_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= '0;
      cpsr_q  <= RESET_CPSR;
      vec_q   <= '0;
      taken_q <= 1'b0;
    end else begin
      pc_q    <= pc_d;
      cpsr_q  <= cpsr_d;
      vec_q   <= vec_d;
      taken_q <= ent_valid;
    end
  end

  assign pc_o           = pc_q;
  assign cpsr_o         = cpsr_q;
  assign spsr_o         = bank_spsr;
  assign lr_o           = bank_lr;
  assign sp_o           = bank_sp;
  assign entry_taken_o  = taken_q;
  assign entry_vector_o = vec_q;

  a_r5_i_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_q |-> cpsr_q[I_BIT]);
  a_r5_f_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_q && vec_q != XLEN'(32'h00) && vec_q != XLEN'(32'h1C)
      |-> cpsr_q[F_BIT] == $past(cpsr_q[F_BIT]));
  a_r3_spsr_saved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_q |-> spsr_o == $past(cpsr_q));
  a_r4_lr_saved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_q |-> lr_o == $past(pc_q) + XLEN'(4));
  a_r8_ret_atomic: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_take |=> pc_q == $past(bank_lr) && cpsr_q == $past(bank_spsr));
  a_r10_vector_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(taken_q) |-> pc_q == vec_q);
endmodule

// File: tb/exc_ctrl_test.sv
module exc_ctrl_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_rst_i = 0, req_und_i = 0, req_swi_i = 0, req_pabt_i = 0;
  logic        req_dabt_i = 0, req_irq_i = 0, req_fiq_i = 0, ret_i = 0;
  logic        pc_ld_i = 0, cpsr_ld_i = 0, sp_we_i = 0;
  logic [31:0] pc_val_i = 0, cpsr_val_i = 0, sp_wdata_i = 0;
  logic [31:0] pc_o, cpsr_o, spsr_o, lr_o, sp_o, entry_vector_o;
  logic        entry_taken_o;
  int          checks = 0, errors = 0;
  bit          done = 0;

  exc_ctrl uut (.*);

  always #2 clk_i = ~clk_i;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic clear_in();
    {req_rst_i, req_und_i, req_swi_i, req_pabt_i, req_dabt_i, req_irq_i, req_fiq_i} = '0;
    {ret_i, pc_ld_i, cpsr_ld_i, sp_we_i} = '0;
  endtask

  task automatic load(logic [31:0] cpsr, logic [31:0] pc);
    cpsr_ld_i = 1; cpsr_val_i = cpsr; pc_ld_i = 1; pc_val_i = pc;
    tick(); clear_in();
  endtask

  task automatic t_reset();
    check("R1 pc", pc_o, 32'h0);
    check("R1 cpsr", cpsr_o, 32'h000000D3);
    check("R1 taken", {31'b0, entry_taken_o}, 32'h0);
  endtask

  task automatic t_swi_and_return();
    load(32'h10, 32'h100);
    check("R11 loads", pc_o, 32'h100);
    req_swi_i = 1; tick(); clear_in();
    check("R2 swi pc", pc_o, 32'h08);
    check("R2 R5 swi cpsr", cpsr_o, 32'h93);
    check("R3 swi spsr", spsr_o, 32'h10);
    check("R4 swi lr", lr_o, 32'h104);
    check("R10 taken", {31'b0, entry_taken_o}, 32'h1);
    check("R10 vector", entry_vector_o, 32'h08);
    tick();
    check("R10 pulse ends", {31'b0, entry_taken_o}, 32'h0);
    ret_i = 1; tick(); clear_in();
    check("R8 ret pc", pc_o, 32'h104);
    check("R8 ret cpsr", cpsr_o, 32'h10);
    check("R3 user spsr", spsr_o, 32'h0);
    ret_i = 1; tick(); clear_in();
    check("R8 user ret pc", pc_o, 32'h104);
    check("R8 user ret cpsr", cpsr_o, 32'h10);
  endtask

  task automatic t_fiq_flags();
    load(32'hA0000010, 32'h200);
    req_fiq_i = 1; tick(); clear_in();
    check("R2 fiq pc", pc_o, 32'h1C);
    check("R2 R5 fiq cpsr", cpsr_o, 32'hA00000D1);
    check("R3 fiq spsr", spsr_o, 32'hA0000010);
    check("R4 fiq lr", lr_o, 32'h204);
  endtask

  task automatic t_prio(string tag, logic [6:0] r, logic [31:0] vec, logic [31:0] cpsr);
    load(32'h10, 32'h300);
    {req_rst_i, req_dabt_i, req_fiq_i, req_irq_i, req_pabt_i, req_und_i, req_swi_i} = r;
    tick(); clear_in();
    check({tag, " pc"}, pc_o, vec);
    check({tag, " cpsr"}, cpsr_o, cpsr);
    check({tag, " lr"}, lr_o, 32'h304);
  endtask

  task automatic t_priority();
    t_prio("R6 rst", 7'b1111111, 32'h00, 32'hD3);
    t_prio("R6 dabt", 7'b0111111, 32'h10, 32'h97);
    t_prio("R6 fiq", 7'b0011111, 32'h1C, 32'hD1);
    t_prio("R6 irq", 7'b0001111, 32'h18, 32'h92);
    t_prio("R6 pabt", 7'b0000111, 32'h0C, 32'h97);
    t_prio("R6 und", 7'b0000011, 32'h04, 32'h9B);
  endtask

  task automatic t_masks();
    load(32'h90, 32'h400);
    req_irq_i = 1; tick(); clear_in();
    check("R7 irq masked pc", pc_o, 32'h400);
    check("R7 irq masked taken", {31'b0, entry_taken_o}, 32'h0);
    load(32'h50, 32'h400);
    req_fiq_i = 1; req_pabt_i = 1; tick(); clear_in();
    check("R7 fiq masked pabt wins", pc_o, 32'h0C);
    load(32'h50, 32'h400);
    req_irq_i = 1; tick(); clear_in();
    check("R5 irq keeps F", cpsr_o, 32'hD2);
  endtask

  task automatic t_sp_bank();
    load(32'h10, 32'h500);
    sp_we_i = 1; sp_wdata_i = 32'h1111; tick(); clear_in();
    check("R9 user sp", sp_o, 32'h1111);
    req_irq_i = 1; tick(); clear_in();
    check("R9 irq sp fresh", sp_o, 32'h0);
    sp_we_i = 1; sp_wdata_i = 32'h2222; tick(); clear_in();
    check("R9 irq sp", sp_o, 32'h2222);
    ret_i = 1; tick(); clear_in();
    check("R9 user sp kept", sp_o, 32'h1111);
  endtask

  task automatic t_same_cycle();
    load(32'h10, 32'h600);
    req_irq_i = 1; tick(); clear_in();
    ret_i = 1; req_und_i = 1; tick(); clear_in();
    check("R11 entry beats ret pc", pc_o, 32'h04);
    check("R11 entry beats ret spsr", spsr_o, 32'h92);
    check("R4 und lr", lr_o, 32'h1C);
    ret_i = 1; pc_ld_i = 1; pc_val_i = 32'hDEAD0; cpsr_ld_i = 1; cpsr_val_i = 32'h1F;
    tick(); clear_in();
    check("R11 ret beats load pc", pc_o, 32'h1C);
    check("R11 ret beats load cpsr", cpsr_o, 32'h92);
  endtask

  initial begin
    #7 rst_ni = 1'b1;
    #1;
    t_reset();
    t_swi_and_return();
    t_fiq_flags();
    t_priority();
    t_masks();
    t_sp_bank();
    t_same_cycle();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        checks++; errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule